// File: doc/BRIEF.md
# Synchronous Burst Address Sequencer

This block drives the word-address sequence for a synchronous burst read out of a 16-bit, word-addressed memory array. It also produces a data-valid strobe and a WAIT flag. A one-cycle latch strobe captures the start address together with the burst configuration: the length code, the wrap-control bit and the first-access latency. After the latency has run out, the block presents one word address per clock. It steps through the words in wrapped or linear order, and it ends the burst after a fixed count or at the top of the address space.

A linear burst that starts off a 4-word boundary pauses once, at the first point where it steps across a 16-word row. During that pause WAIT is high and the strobe is low. The length of the pause equals the start offset inside its 4-word group. A clock-edge select input moves the output updates from the rising edge to the falling edge that follows it.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low and after its release, addr_o is 0 and valid_o and wait_o are low until the first latch.
- R2: The clock edge that samples start_i high latches addr_i. From that edge, for L cycles (L = latency_i, with 0 treated as 1), wait_o is high, valid_o is low and addr_o shows the start address. valid_o rises at the L-th edge after the latch.
- R3: Length code blen_i = 3'b001, 3'b010 and 3'b011 give exactly 4, 8 and 16 valid words. After the last word, valid_o and wait_o both go low.
- R4: With nowrap_i = 0 and a fixed length N, addresses wrap inside the aligned N-word block (4-word from 2: 2,3,0,1).
- R5: With nowrap_i = 1 and a fixed length N, addresses are start+0 through start+N-1 and may cross the N-word boundary (8-word from 3: 3..10).
- R6: blen_i = 3'b111, and every code not listed in R3, gives a continuous burst. It is linear whatever nowrap_i holds, and it ends after the all-ones address has been presented.
- R7: In a linear burst whose start offset k = start[1:0] is nonzero, the first step from a word with address bits [3:0] = 4'hF into the next row inserts k cycles with valid_o low and wait_o high. The burst then resumes at the next address. With k = 0 no pause occurs.
- R8: The row pause happens at most once per burst. Later row crossings in a continuous burst have no pause.
- R9: Wrapped bursts, and linear bursts that cross no row boundary, never pause.
- R10: A latch strobe during a burst abandons it, and the new burst starts from its own latch as in R2.
- R11: With fall_edge_i = 1, the outputs follow the same sequence but update on the falling clock edge. Half a cycle after a rising edge they still show the values of the previous cycle.
- R12: valid_o and wait_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Latch strobe for address and configuration |
| addr_i | input | AW | Burst start word address |
| blen_i | input | 3 | Burst length code |
| nowrap_i | input | 1 | 1 = linear fixed-length burst, 0 = wrapped |
| fall_edge_i | input | 1 | 1 = outputs change on the falling edge |
| latency_i | input | LW | First-access latency in cycles |
| addr_o | output | AW | Current word address |
| valid_o | output | 1 | Word address carries valid data |
| wait_o | output | 1 | Data not yet available (latency or row pause) |

## Verification
A faulty countdown moves the first valid word or the end of a row pause by whole cycles, and the change is visible at valid_o in the cycle where it happens. A wrong crossed-row flag or a wrong offset register shows up as a missing, extra or wrongly sized pause one cycle after a word ending in 4'hF. A wrong latched length or wrap mode shows up as a wrong address or a wrong burst end on the next word. The bench rebuilds each expected cycle trace from the start address, code, mode and latency, and compares every cycle.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_DATA, ST_STALL} bsq_state_e;
  localparam int unsigned ROW_W = 4;  // 16-word row
  localparam int unsigned GRP_W = 2;  // 4-word group
  localparam logic [2:0] BL_4  = 3'b001;
  localparam logic [2:0] BL_8  = 3'b010;
  localparam logic [2:0] BL_16 = 3'b011;
endpackage

// File: rtl/bsq_len_decode.sv
module bsq_len_decode
  import bsq_pkg::*;
(
  input  logic [2:0] blen_i,
  output logic [2:0] lg_o,
  output logic       cont_o
);
  always_comb begin
    cont_o = 1'b0;
    unique case (blen_i)
      BL_4:    lg_o = 3'd2;
      BL_8:    lg_o = 3'd3;
      BL_16:   lg_o = 3'd4;
      default: begin
        lg_o   = 3'd4;
        cont_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/bsq_next_addr.sv
module bsq_next_addr
  import bsq_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    lg_i,
  input  logic          linear_i,
  output logic [AW-1:0] next_o,
  output logic          row_end_o
);
  logic [AW-1:0] mask;
  logic [AW-1:0] inc;

  assign mask      = ~({AW{1'b1}} << lg_i);
  assign inc       = addr_i + AW'(1);
  assign next_o    = linear_i ? inc : ((addr_i & ~mask) | (inc & mask));
  assign row_end_o = &addr_i[ROW_W-1:0];
endmodule

// File: rtl/bsq_edge_stage.sv
module bsq_edge_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fall_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] neg_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= '0;
    else         neg_q <= d_i;
  end

  assign q_o = fall_i ? neg_q : d_i;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    blen_i,
  input  logic          nowrap_i,
  input  logic          fall_edge_i,
  input  logic [LW-1:0] latency_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic          wait_o
);
  localparam int unsigned LEN_W = ROW_W + 1;
  localparam int unsigned OW    = AW + 2;

  bsq_state_e       state_q;
  logic [AW-1:0]    addr_q;
  logic             valid_q, wait_q;
  logic [LW-1:0]    cnt_q;
  logic [LEN_W-1:0] left_q;
  logic [2:0]       lg_q;
  logic             cont_q, linear_q, crossed_q;
  logic [GRP_W-1:0] ofs_q;

  logic [2:0]       dec_lg;
  logic             dec_cont;
  logic [AW-1:0]    next_addr;
  logic             row_end;
  logic [LW-1:0]    lat_m1;
  logic             last_word;
  logic [OW-1:0]    out_vec;

  bsq_len_decode u_dec (
    .blen_i (blen_i),
    .lg_o   (dec_lg),
    .cont_o (dec_cont)
  );

  bsq_next_addr #(.AW(AW)) u_next (
    .addr_i    (addr_q),
    .lg_i      (lg_q),
    .linear_i  (linear_q),
    .next_o    (next_addr),
    .row_end_o (row_end)
  );

  assign lat_m1    = (latency_i == '0) ? '0 : latency_i - LW'(1);
  assign last_word = cont_q ? (&addr_q) : (left_q == LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      valid_q   <= 1'b0;
      wait_q    <= 1'b0;
      cnt_q     <= '0;
      left_q    <= '0;
      lg_q      <= 3'd2;
      cont_q    <= 1'b0;
      linear_q  <= 1'b0;
      crossed_q <= 1'b0;
      ofs_q     <= '0;
    end else if (start_i) begin
      state_q   <= ST_LAT;
      addr_q    <= addr_i;
      valid_q   <= 1'b0;
      wait_q    <= 1'b1;
      cnt_q     <= lat_m1;
      left_q    <= LEN_W'(1) << dec_lg;
      lg_q      <= dec_lg;
      cont_q    <= dec_cont;
      linear_q  <= nowrap_i | dec_cont;
      crossed_q <= 1'b0;
      ofs_q     <= addr_i[GRP_W-1:0];
    end else begin
      unique case (state_q)
        ST_LAT, ST_STALL: begin
          if (cnt_q == '0) begin
            state_q <= ST_DATA;
            valid_q <= 1'b1;
            wait_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q - LW'(1);
          end
        end
        ST_DATA: begin
          if (last_word) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b0;
            wait_q  <= 1'b0;
          end else begin
            addr_q <= next_addr;
            left_q <= left_q - LEN_W'(1);
            // first row crossing of a linear burst: one-time pause
            if (linear_q && row_end && !crossed_q) begin
              crossed_q <= 1'b1;
              if (ofs_q != '0) begin
                state_q <= ST_STALL;
                cnt_q   <= LW'(ofs_q) - LW'(1);
                valid_q <= 1'b0;
                wait_q  <= 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  bsq_edge_stage #(.W(OW)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (fall_edge_i),
    .d_i    ({addr_q, valid_q, wait_q}),
    .q_o    (out_vec)
  );

  assign addr_o  = out_vec[OW-1:2];
  assign valid_o = out_vec[1];
  assign wait_o  = out_vec[0];
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] addr_i,
  input logic [2:0]    blen_i,
  input logic          nowrap_i,
  input logic          fall_edge_i,
  input logic [AW-1:0] addr_o,
  input logic          valid_o,
  input logic          wait_o
);
  a_r12_valid_wait_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && wait_o));

  a_r2_latch_enters_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !fall_edge_i) |=>
      (fall_edge_i || (wait_o && !valid_o && addr_o == $past(addr_i))));

  a_r4_wrap4_in_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && !start_i && !$past(start_i) && !nowrap_i &&
     blen_i == 3'b001 && !fall_edge_i && !$past(fall_edge_i))
      |-> addr_o[AW-1:2] == $past(addr_o[AW-1:2]));

  a_r5_linear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && !start_i && !$past(start_i) && nowrap_i &&
     !fall_edge_i && !$past(fall_edge_i))
      |-> (addr_o - $past(addr_o)) == AW'(1));

  a_r7_pause_at_row_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wait_o) && $past(valid_o) && !$past(start_i) &&
     !fall_edge_i && !$past(fall_edge_i))
      |-> $past(addr_o[3:0]) == 4'hF);
endmodule

bind burst_addr_seq bsq_checker #(.AW(AW)) u_bsq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .addr_i      (addr_i),
  .blen_i      (blen_i),
  .nowrap_i    (nowrap_i),
  .fall_edge_i (fall_edge_i),
  .addr_o      (addr_o),
  .valid_o     (valid_o),
  .wait_o      (wait_o)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;
  localparam int unsigned AW = 16;
  localparam int unsigned LW = 4;
  localparam int MAXE = 160;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [2:0]    blen_i = 3'b001;
  logic          nowrap_i = 1'b1;
  logic          fall_edge_i = 1'b0;
  logic [LW-1:0] latency_i = '0;
  logic [AW-1:0] addr_o;
  logic          valid_o, wait_o;

  int checks = 0;
  int errors = 0;

  logic          exp_v [MAXE];
  logic          exp_w [MAXE];
  logic [AW-1:0] exp_a [MAXE];
  int            exp_n;

  burst_addr_seq #(.AW(AW), .LW(LW)) dut_i (.*);

  always #2 clk_i = ~clk_i;  // 250 MHz

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, act=running exp=finished");
    summary();
    $finish;
  end

  task automatic push(input logic v, input logic w, input logic [AW-1:0] a);
    if (exp_n < MAXE) begin
      exp_v[exp_n] = v;
      exp_w[exp_n] = w;
      exp_a[exp_n] = a;
      exp_n++;
    end
  endtask

  // expected cycle trace from the latch edge onward
  task automatic build(input logic [AW-1:0] st, input logic [2:0] bl,
                       input logic nw, input int lat);
    int sz, n, k;
    logic cont, crossed;
    logic [AW-1:0] a, na, msk;
    exp_n = 0;
    case (bl)
      3'b001:  sz = 4;
      3'b010:  sz = 8;
      3'b011:  sz = 16;
      default: sz = 0;
    endcase
    cont = (sz == 0);
    for (int i = 0; i < ((lat == 0) ? 1 : lat); i++) push(1'b0, 1'b1, st);
    a = st; crossed = 1'b0; k = int'(st[1:0]); n = 0;
    msk = AW'(sz - 1);
    while (1) begin
      push(1'b1, 1'b0, a);
      n++;
      if (cont ? (a == {AW{1'b1}}) : (n == sz)) break;
      if (nw || cont) begin
        na = a + AW'(1);
        if (a[3:0] == 4'hF && !crossed) begin
          crossed = 1'b1;
          for (int j = 0; j < k; j++) push(1'b0, 1'b1, na);
        end
      end else begin
        na = (a & ~msk) | ((a + AW'(1)) & msk);
      end
      a = na;
    end
    push(1'b0, 1'b0, a);
  endtask

  task automatic cmp(input string tag, input int i, input int e);
    logic ok;
    checks++;
    ok = (valid_o === exp_v[e]) && (wait_o === exp_w[e]) &&
         (!(exp_v[e] || exp_w[e]) || addr_o === exp_a[e]);
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: act v=%b w=%b a=%h exp v=%b w=%b a=%h",
               tag, i, valid_o, wait_o, addr_o, exp_v[e], exp_w[e], exp_a[e]);
    end
    if (valid_o && wait_o) begin
      checks++;
      errors++;
      $display("FAIL R12 cycle %0d: act v=1 w=1 exp not both", i);
    end
  endtask

  // called at posedge+1; returns at posedge+1
  task automatic run_burst(input string tag, input logic [AW-1:0] st,
                           input logic [2:0] bl, input logic nw, input int lat,
                           input logic fe, input int limit);
    int len;
    build(st, bl, nw, lat);
    start_i = 1'b1; addr_i = st; blen_i = bl; nowrap_i = nw;
    latency_i = LW'(lat); fall_edge_i = fe;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    len = (limit > 0 && limit < exp_n) ? limit : exp_n;
    for (int i = 0; i < len; i++) begin
      if (fe) begin
        if (i > 0) cmp("R11", i, i - 1);  // still previous cycle's values
        #2;
        cmp(tag, i, i);
      end else begin
        cmp(tag, i, i);
      end
      @(posedge clk_i); #1;
    end
  endtask

  initial begin
    int unsigned r;
    logic [2:0] bl;
    logic [AW-1:0] st;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk_i);
    #1;
    checks++;
    if (addr_o !== '0 || valid_o !== 1'b0 || wait_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: act a=%h v=%b w=%b exp 0 0 0", addr_o, valid_o, wait_o);
    end
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    checks++;
    if (addr_o !== '0 || valid_o !== 1'b0 || wait_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 after release: act a=%h v=%b w=%b exp 0 0 0", addr_o, valid_o, wait_o);
    end

    run_burst("R4", 16'h0002, 3'b001, 1'b0, 2, 1'b0, 0);   // 2,3,0,1
    run_burst("R5", 16'h0003, 3'b010, 1'b1, 3, 1'b0, 0);   // 3..10
    run_burst("R3", 16'h0020, 3'b011, 1'b1, 1, 1'b0, 0);   // 16 words aligned
    run_burst("R7", 16'h001D, 3'b011, 1'b1, 4, 1'b0, 0);   // k=1 pause
    run_burst("R7", 16'h000F, 3'b001, 1'b1, 4, 1'b0, 0);   // k=3 = latency-1
    run_burst("R7", 16'h000C, 3'b010, 1'b1, 2, 1'b0, 0);   // aligned, no pause
    run_burst("R9", 16'h0025, 3'b011, 1'b0, 2, 1'b0, 0);   // wrapped, no pause
    run_burst("R9", 16'h0031, 3'b001, 1'b1, 2, 1'b0, 0);   // no crossing
    run_burst("R8", 16'hFFC5, 3'b111, 1'b0, 2, 1'b0, 0);   // continuous, one pause
    run_burst("R6", 16'hFFF8, 3'b100, 1'b1, 1, 1'b0, 0);   // reserved code
    run_burst("R2", 16'h0101, 3'b001, 1'b0, 0, 1'b0, 0);   // latency 0 -> 1
    run_burst("R2", 16'h0202, 3'b001, 1'b1, 15, 1'b0, 0);
    run_burst("R10", 16'h0040, 3'b011, 1'b1, 2, 1'b0, 6);  // abandoned
    run_burst("R10", 16'h0081, 3'b001, 1'b0, 3, 1'b0, 0);
    run_burst("R11", 16'h0005, 3'b010, 1'b0, 2, 1'b1, 0);
    run_burst("R11", 16'h0017, 3'b010, 1'b1, 3, 1'b1, 0);

    for (int n = 0; n < 60; n++) begin
      r = $urandom;
      case (r % 5)
        0: bl = 3'b001;
        1: bl = 3'b010;
        2: bl = 3'b011;
        3: bl = 3'b111;
        default: bl = 3'b000;
      endcase
      st = AW'($urandom);
      if (bl == 3'b111 || bl == 3'b000) st[AW-1:6] = '1;
      run_burst((bl == 3'b111 || bl == 3'b000) ? "R6" : (r[8] ? "R5" : "R4"),
                st, bl, r[8], int'((r >> 9) % 8), ((r >> 12) % 4) == 0,
                ((r >> 14) % 6 == 0) ? 5 : 0);
    end

    summary();
    $finish;
  end
endmodule